// File: doc/BRIEF.md
# Nibble-Serial ARP Request Detector

This block listens to the receive side of a 4-bit media-independent interface and picks out address resolution requests asking for the local station. It hunts for the preamble and start delimiter, rebuilds bytes from nibble pairs, and walks the Ethernet and ARP headers byte by byte. It keeps a running CRC-32 over everything after the delimiter.

When the receive-valid line drops at the end of a frame, the block decides whether to accept it. A frame is accepted only if it has a whole number of bytes, reaches the minimum length, carries the expected header constants, names the local IPv4 address as its target and ends with a correct check sequence. On acceptance it emits a single-cycle pulse. At the same time it updates two held outputs with the requester's hardware and protocol addresses, which a separate reply transmitter can use.

Top module: `arp_req_rx`

## Requirements
- R1: After synchronous reset, `req_hit` is 0 and `peer_mac` and `peer_ip` are all zeros.
- R2: A frame is recognised only after at least 15 consecutive valid nibbles of 0x5 are followed by a nibble 0xD. This is seven 0x55 bytes and one 0xD5 byte, each sent low nibble first. Fewer than 15 such nibbles cause the whole frame to be ignored.
- R3: Each byte is assembled low nibble first, and multi-byte fields are taken most significant byte first. `peer_mac` holds bytes 22..27 after the delimiter, with byte 22 in bits 47:40. `peer_ip` holds bytes 28..31, with byte 28 in bits 31:24.
- R4: Bytes 0..5 (destination address) must all be 0xFF, or the frame produces no pulse.
- R5: Bytes 12..13 (frame type) must be 0x08, 0x06, or the frame produces no pulse.
- R6: Bytes 14..15 must be 0x00 0x01 (hardware type), bytes 16..17 must be 0x08 0x00 (protocol type), byte 18 must be 6 and byte 19 must be 4. Any other value suppresses the pulse.
- R7: Bytes 20..21 (operation) must be 0x00 0x01. A reply (0x00 0x02) produces no pulse.
- R8: Bytes 38..41 (target protocol address) must equal `local_ip` taken most significant byte first. If they do not, the pulse is suppressed.
- R9: The last four bytes are a CRC-32 check sequence: reflected polynomial 0x04C11DB7, preset to all ones, inverted, and sent least significant byte first. A frame whose check fails produces no pulse.
- R10: The frame is abandoned with no pulse if receive-valid drops before 46 bytes have arrived, or drops after an odd number of data nibbles. The next frame is then parsed normally.
- R11: Bytes between byte 42 and the check sequence are accepted whatever their value.
- R12: An accepted frame raises `req_hit` for exactly one cycle, two clock edges after the first edge that samples receive-valid low. `peer_mac` and `peer_ip` change only together with that pulse and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data valid |
| rx_nib | input | 4 | Receive data nibble |
| local_ip | input | 32 | IPv4 address of this station |
| req_hit | output | 1 | One-cycle pulse for an accepted request |
| peer_mac | output | 48 | Hardware address of the last accepted requester |
| peer_ip | output | 32 | Protocol address of the last accepted requester |

## Verification
Valid requests are sent with no padding, with junk padding and with a preamble longer than the minimum. Each one must pulse and load the exact sender fields, which shows that nibble and byte order are right. Each header constant, the destination, the operation and the target address is then broken alone, in an otherwise valid frame with a fresh check sequence. This shows that every comparison gates the pulse on its own. Corrupted payload or check bytes separate the CRC gate from the field gates. Short preambles, truncated frames and an extra trailing nibble exercise the length and alignment rules, and a good frame after each failure shows the block has recovered.

// File: rtl/arp_rx_pkg.sv
package arp_rx_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;
    // register remainder after a good frame plus its own check sequence
    localparam logic [31:0] CRC_GOOD_REM  = 32'hDEBB20E3;

    localparam logic [3:0] NIB_PRE = 4'h5;
    localparam logic [3:0] NIB_SFD = 4'hD;

    localparam int SMAC_POS     = 22;
    localparam int SIP_POS      = 28;
    localparam int TIP_POS      = 38;
    localparam int ADDR_BYTES   = 6;
    localparam int IP_BYTES     = 4;
    localparam int PAYLOAD_END  = TIP_POS + IP_BYTES;
    localparam int FCS_BYTES    = 4;
    localparam int MIN_FRAME    = PAYLOAD_END + FCS_BYTES;

    typedef enum logic {FR_HUNT, FR_DATA} framer_st_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] dat;
    } rx_beat_t;

    typedef struct packed {
        logic       care;
        logic [7:0] val;
    } hdr_exp_t;

    function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                  input logic [7:0]  d);
        logic [31:0] c;
        c = c_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY_REFL;
            else             c = c >> 1;
        end
        return c;
    endfunction

    // fixed header byte expected at a given offset after the delimiter
    function automatic hdr_exp_t hdr_expect(input int pos);
        hdr_exp_t e;
        e.care = 1'b1;
        case (pos)
            0, 1, 2, 3, 4, 5: e.val = 8'hFF;
            12: e.val = 8'h08;
            13: e.val = 8'h06;
            14: e.val = 8'h00;
            15: e.val = 8'h01;
            16: e.val = 8'h08;
            17: e.val = 8'h00;
            18: e.val = 8'h06;
            19: e.val = 8'h04;
            20: e.val = 8'h00;
            21: e.val = 8'h01;
            default: begin
                e.care = 1'b0;
                e.val  = 8'h00;
            end
        endcase
        return e;
    endfunction

    function automatic logic [7:0] ip_byte(input logic [31:0] ip, input int k);
        case (k)
            0: return ip[31:24];
            1: return ip[23:16];
            2: return ip[15:8];
            3: return ip[7:0];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/mii_nibble_framer.sv
module mii_nibble_framer
    import arp_rx_pkg::*;
#(
    parameter int PRE_NIBBLES = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_dv,
    input  logic [3:0] rx_nib,
    output rx_beat_t   beat,
    output logic       sof,
    output logic       eof,
    output logic       eof_aligned
);
    localparam int CW = $clog2(PRE_NIBBLES + 1);
    localparam logic [CW-1:0] PRE_FULL = CW'(PRE_NIBBLES);

    framer_st_e    st;
    logic [CW-1:0] pre_cnt;
    logic          half;
    logic [3:0]    low_nib;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= FR_HUNT;
            pre_cnt     <= '0;
            half        <= 1'b0;
            low_nib     <= '0;
            beat        <= '0;
            sof         <= 1'b0;
            eof         <= 1'b0;
            eof_aligned <= 1'b0;
        end else begin
            sof      <= 1'b0;
            eof      <= 1'b0;
            beat.vld <= 1'b0;
            case (st)
                FR_HUNT: begin
                    if (!rx_dv) begin
                        pre_cnt <= '0;
                    end else if (rx_nib == NIB_PRE) begin
                        if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
                    end else if (rx_nib == NIB_SFD && pre_cnt == PRE_FULL) begin
                        st      <= FR_DATA;
                        sof     <= 1'b1;
                        half    <= 1'b0;
                        pre_cnt <= '0;
                    end else begin
                        pre_cnt <= '0;
                    end
                end
                FR_DATA: begin
                    if (!rx_dv) begin
                        eof         <= 1'b1;
                        eof_aligned <= !half;
                        st          <= FR_HUNT;
                    end else if (!half) begin
                        low_nib <= rx_nib;
                        half    <= 1'b1;
                    end else begin
                        beat.vld <= 1'b1;
                        beat.dat <= {rx_nib, low_nib};
                        half     <= 1'b0;
                    end
                end
                default: st <= FR_HUNT;
            endcase
        end
    end

    assert_sof_after_delim_R2: assert property (@(posedge clk) disable iff (rst)
        sof |-> ($past(rx_dv) && $past(rx_nib) == NIB_SFD));

    assert_byte_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        beat.vld |=> !beat.vld);

endmodule

// File: rtl/crc32_byte_acc.sv
module crc32_byte_acc
    import arp_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  dat,
    output logic [31:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clear) crc <= CRC_PRESET;
        else if (en)      crc <= crc_step_byte(crc, dat);
    end
endmodule

// File: rtl/arp_req_parser.sv
module arp_req_parser
    import arp_rx_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  rx_beat_t    beat,
    input  logic        sof,
    input  logic        eof,
    input  logic        eof_aligned,
    input  logic [31:0] crc_val,
    input  logic [31:0] local_ip,
    output logic        req_hit,
    output logic [47:0] peer_mac,
    output logic [31:0] peer_ip
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic             in_frame;
    logic             hdr_ok;
    logic [IDX_W-1:0] idx;
    logic [47:0]      smac_acc;
    logic [31:0]      sip_acc;

    int       pos;
    hdr_exp_t exp_b;
    logic     tip_bad;
    logic     byte_bad;
    logic     frame_good;
    logic     bvld;
    logic [7:0] bdat;

    always_comb begin
        bvld     = beat.vld;
        bdat     = beat.dat;
        pos      = int'(idx);
        exp_b    = hdr_expect(pos);
        tip_bad  = (pos >= TIP_POS) && (pos < TIP_POS + IP_BYTES) &&
                   (bdat != ip_byte(local_ip, pos - TIP_POS));
        byte_bad = (exp_b.care && bdat != exp_b.val) || tip_bad;
        frame_good = in_frame && eof_aligned && hdr_ok &&
                     (pos >= MIN_FRAME) && (crc_val == CRC_GOOD_REM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            hdr_ok   <= 1'b0;
            idx      <= '0;
            smac_acc <= '0;
            sip_acc  <= '0;
            req_hit  <= 1'b0;
            peer_mac <= '0;
            peer_ip  <= '0;
        end else begin
            req_hit <= 1'b0;
            if (sof) begin
                in_frame <= 1'b1;
                hdr_ok   <= 1'b1;
                idx      <= '0;
            end else if (bvld && in_frame) begin
                if (idx != IDX_MAX) idx <= idx + 1'b1;
                if (byte_bad) hdr_ok <= 1'b0;
                if (pos >= SMAC_POS && pos < SMAC_POS + ADDR_BYTES)
                    smac_acc <= {smac_acc[39:0], bdat};
                if (pos >= SIP_POS && pos < SIP_POS + IP_BYTES)
                    sip_acc <= {sip_acc[23:0], bdat};
            end else if (eof) begin
                in_frame <= 1'b0;
                if (frame_good) begin
                    req_hit  <= 1'b1;
                    peer_mac <= smac_acc;
                    peer_ip  <= sip_acc;
                end
            end
        end
    end

    assert_bcast_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (bvld && in_frame && !sof && idx == '0 && bdat != 8'hFF) |=> !hdr_ok);

    assert_crc_gate_R9: assert property (@(posedge clk) disable iff (rst)
        req_hit |-> $past(crc_val) == CRC_GOOD_REM);

    assert_hit_after_end_R12: assert property (@(posedge clk) disable iff (rst)
        req_hit |-> $past(eof));

    assert_hit_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        req_hit |=> !req_hit);

    assert_hold_mac_R12: assert property (@(posedge clk) disable iff (rst)
        !req_hit |-> ($stable(peer_mac) && $stable(peer_ip)));

endmodule

// File: rtl/arp_req_rx.sv
module arp_req_rx
    import arp_rx_pkg::*;
#(
    parameter int PRE_NIBBLES = 15,
    parameter int IDX_W       = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_dv,
    input  logic [3:0]  rx_nib,
    input  logic [31:0] local_ip,
    output logic        req_hit,
    output logic [47:0] peer_mac,
    output logic [31:0] peer_ip
);
    rx_beat_t    beat;
    logic        sof;
    logic        eof;
    logic        eof_aligned;
    logic [31:0] crc_val;

    mii_nibble_framer #(.PRE_NIBBLES(PRE_NIBBLES)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .rx_dv       (rx_dv),
        .rx_nib      (rx_nib),
        .beat        (beat),
        .sof         (sof),
        .eof         (eof),
        .eof_aligned (eof_aligned)
    );

    crc32_byte_acc u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (sof),
        .en    (beat.vld),
        .dat   (beat.dat),
        .crc   (crc_val)
    );

    arp_req_parser #(.IDX_W(IDX_W)) u_parser (
        .clk         (clk),
        .rst         (rst),
        .beat        (beat),
        .sof         (sof),
        .eof         (eof),
        .eof_aligned (eof_aligned),
        .crc_val     (crc_val),
        .local_ip    (local_ip),
        .req_hit     (req_hit),
        .peer_mac    (peer_mac),
        .peer_ip     (peer_ip)
    );

    assert_no_hit_while_valid_R12: assert property (@(posedge clk) disable iff (rst)
        req_hit |-> !$past(rx_dv));

endmodule

// File: tb/arp_req_rx_test.sv
module arp_req_rx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_dv = 1'b0;
    logic [3:0]  rx_nib = 4'h0;
    logic [31:0] local_ip = 32'hC0A8_0107;
    logic        req_hit;
    logic [47:0] peer_mac;
    logic [31:0] peer_ip;

    arp_req_rx uut (
        .clk      (clk),
        .rst      (rst),
        .rx_dv    (rx_dv),
        .rx_nib   (rx_nib),
        .local_ip (local_ip),
        .req_hit  (req_hit),
        .peer_mac (peer_mac),
        .peer_ip  (peer_ip)
    );

    always #4 clk = ~clk;

    int   checks = 0;
    int   errors = 0;
    int   hit_cnt = 0;
    int   wide_cnt = 0;
    bit   hit_prev = 1'b0;
    bit   done = 1'b0;
    logic [7:0] frm [0:127];
    int   flen = 0;

    always @(negedge clk) begin
        if (req_hit) hit_cnt++;
        if (req_hit && hit_prev) wide_cnt++;
        hit_prev = req_hit;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic put(input logic [3:0] n);
        @(negedge clk);
        rx_dv  = 1'b1;
        rx_nib = n;
    endtask

    task automatic make_req(input logic [47:0] mac, input logic [31:0] sip,
                            input logic [31:0] tip, input int npad);
        for (int i = 0; i < 6; i++) frm[i] = 8'hFF;
        frm[6] = 8'h02; frm[7] = 8'h11; frm[8] = 8'h22;
        frm[9] = 8'h33; frm[10] = 8'h44; frm[11] = 8'h55;
        frm[12] = 8'h08; frm[13] = 8'h06; frm[14] = 8'h00; frm[15] = 8'h01;
        frm[16] = 8'h08; frm[17] = 8'h00; frm[18] = 8'h06; frm[19] = 8'h04;
        frm[20] = 8'h00; frm[21] = 8'h01;
        for (int i = 0; i < 6; i++) frm[22+i] = mac[8*(5-i) +: 8];
        for (int i = 0; i < 4; i++) frm[28+i] = sip[8*(3-i) +: 8];
        for (int i = 0; i < 6; i++) frm[32+i] = 8'h00;
        for (int i = 0; i < 4; i++) frm[38+i] = tip[8*(3-i) +: 8];
        for (int i = 0; i < npad; i++) frm[42+i] = 8'h3C ^ 8'(i * 7);
        flen = 42 + npad;
    endtask

    task automatic seal();
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < flen; i++)
            for (int b = 0; b < 8; b++)
                c = (c[0] ^ frm[i][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        c = ~c;
        for (int i = 0; i < 4; i++) frm[flen+i] = c[8*i +: 8];
        flen = flen + 4;
    endtask

    // cut < 0 sends every nibble; extra adds one stray nibble at the end
    task automatic send(input int pre, input int cut, input bit extra);
        int n;
        n = 0;
        for (int i = 0; i < pre; i++) put(4'h5);
        put(4'hD);
        for (int i = 0; i < flen; i++) begin
            if (cut >= 0 && n >= cut) break;
            put(frm[i][3:0]); n++;
            if (cut >= 0 && n >= cut) break;
            put(frm[i][7:4]); n++;
        end
        if (extra) put(4'h7);
        @(negedge clk);
        rx_dv = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_hits(input int base, input int want, input string req,
                               input string what);
        chk(hit_cnt - base == want, req, what, 64'(hit_cnt - base), 64'(want));
    endtask

    task automatic t_reset();
        chk(req_hit == 1'b0, "R1", "hit after reset", 64'(req_hit), 0);
        chk(peer_mac == 48'h0, "R1", "mac after reset", 64'(peer_mac), 0);
        chk(peer_ip == 32'h0, "R1", "ip after reset", 64'(peer_ip), 0);
    endtask

    task automatic t_good(input logic [47:0] mac, input logic [31:0] sip,
                          input int npad, input int pre, input string req);
        int b;
        b = hit_cnt;
        make_req(mac, sip, local_ip, npad);
        seal();
        send(pre, -1, 1'b0);
        expect_hits(b, 1, req, "good request pulse");
        chk(peer_mac == mac, "R3", "captured mac", 64'(peer_mac), 64'(mac));
        chk(peer_ip == sip, "R3", "captured ip", 64'(peer_ip), 64'(sip));
        chk(wide_cnt == 0, "R12", "pulse width", 64'(wide_cnt), 0);
    endtask

    task automatic t_poke(input int pos, input logic [7:0] val, input string req,
                          input string what);
        int b;
        logic [47:0] m0;
        b = hit_cnt;
        m0 = peer_mac;
        make_req(48'hDEAD_0000_0001, 32'h0A00_0001, local_ip, 4);
        frm[pos] = val;
        seal();
        send(15, -1, 1'b0);
        expect_hits(b, 0, req, what);
        chk(peer_mac == m0, "R12", "mac held on reject", 64'(peer_mac), 64'(m0));
    endtask

    task automatic t_wrong_ip();
        int b;
        b = hit_cnt;
        make_req(48'hDEAD_0000_0002, 32'h0A00_0002, local_ip ^ 32'h1, 0);
        seal();
        send(15, -1, 1'b0);
        expect_hits(b, 0, "R8", "other target ip");
    endtask

    task automatic t_bad_fcs(input int pos);
        int b;
        b = hit_cnt;
        make_req(48'hDEAD_0000_0003, 32'h0A00_0003, local_ip, 2);
        seal();
        frm[pos] = frm[pos] ^ 8'h10;
        send(15, -1, 1'b0);
        expect_hits(b, 0, "R9", "corrupted frame");
    endtask

    task automatic t_short_pre();
        int b;
        b = hit_cnt;
        make_req(48'hDEAD_0000_0004, 32'h0A00_0004, local_ip, 0);
        seal();
        send(14, -1, 1'b0);
        expect_hits(b, 0, "R2", "preamble too short");
    endtask

    task automatic t_trunc(input int cut, input bit extra, input string what);
        int b;
        b = hit_cnt;
        make_req(48'hDEAD_0000_0005, 32'h0A00_0005, local_ip, 0);
        seal();
        send(15, cut, extra);
        expect_hits(b, 0, "R10", what);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good(48'h0012_3456_789A, 32'hC0A8_0164, 0, 15, "R3");
        t_good(48'hAA00_BB11_CC22, 32'hAC10_0005, 18, 15, "R11");
        t_good(48'h0102_0304_0506, 32'h0A0B_0C0D, 3, 22, "R2");
        t_wrong_ip();
        local_ip = 32'h0A00_00FE;
        t_good(48'h7766_5544_3322, 32'h0A00_0001, 0, 15, "R8");
        t_poke(0, 8'h00, "R4", "unicast destination");
        t_poke(5, 8'hFE, "R4", "last destination byte");
        t_poke(13, 8'h00, "R5", "ipv4 frame type");
        t_poke(15, 8'h06, "R6", "hardware type");
        t_poke(16, 8'h86, "R6", "protocol type");
        t_poke(18, 8'h08, "R6", "hardware length");
        t_poke(19, 8'h10, "R6", "protocol length");
        t_poke(21, 8'h02, "R7", "reply opcode");
        t_bad_fcs(24);
        t_bad_fcs(47);
        t_short_pre();
        t_trunc(2 * 40, 1'b0, "drop inside payload");
        t_trunc(2 * 44 + 1, 1'b0, "drop inside check sequence");
        t_trunc(-1, 1'b1, "stray trailing nibble");
        t_good(48'h0A0B_0C0D_0E0F, 32'h0A00_0009, 1, 15, "R10");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule